// File: doc/BRIEF.md
# Register Access Command Channel

This block is the host end of a single-command register access path toward a power-management slave device. Software writes one packed command word. The word holds a direction flag, a halfword address and write data. The block then runs a four-state sequencer that raises a request on a simple request/acknowledge slave interface. For reads, it waits for the slave's data beat and then parks holding the captured data until software releases it with a valid-clear write. The whole sequencer state is visible in a packed status word, together with the read data, a request flag, a sync-idle flag and an init-done flag.

The slave side is a plain handshake. The block holds `slv_req` with address, direction and write data until `slv_ack`. For a read, the slave later returns one `slv_rvalid` beat with `slv_rdata`. Writes complete on the acknowledge and need no software action. Reads stay parked until released. A command that arrives while the sequencer is not idle is dropped, and a sticky error output records it.

Top module: `regacc_channel`

## Requirements
- R1: After reset the state field is 0, the request flag is 0, sync-idle (status bit 20) is 1, the read data field is 0, `cmd_err` is 0 and `slv_req` is 0.
- R2: An accepted command uses bit 31 as the write flag (1 = write), bits 30:16 as the halfword address and bits 15:0 as write data. On the slave side, `slv_addr` equals the halfword address shifted left by one, so it is always even.
- R3: Status bits 18:16 report the state with IDLE=0, REQUEST=2, WAIT_DATA=4 and WAIT_CLEAR=6. No other code ever appears.
- R4: The request flag (status bit 19) and `slv_req` go high in the cycle after a command is accepted. They stay high until the cycle after `slv_ack` is seen.
- R5: A write returns to IDLE in the cycle after its acknowledge, with no valid-clear write.
- R6: A read moves from REQUEST to WAIT_DATA on the acknowledge. It moves to WAIT_CLEAR when `slv_rvalid` arrives, capturing `slv_rdata` into status bits 15:0. It holds that state and data for as long as no valid-clear with value 1 arrives.
- R7: A valid-clear write with `vclr_val`=1 in WAIT_CLEAR returns the state to IDLE on the next cycle. A valid-clear write with `vclr_val`=0 has no effect.
- R8: A command written while the state is not IDLE is ignored: no slave request is made and the slave register is unchanged. `cmd_err` rises the next cycle and stays high until reset.
- R9: Sync-idle (status bit 20) is 0 in REQUEST and WAIT_DATA and 1 in IDLE and WAIT_CLEAR.
- R10: Status bit 21 follows the `init_done` input.
- R11: With the default configuration the read data field keeps the last captured value after the return to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_data | input | 32 | Command word: write flag, halfword address, write data |
| vclr_wr | input | 1 | Valid-clear write strobe |
| vclr_val | input | 1 | Value written with the valid-clear strobe |
| init_done | input | 1 | Initialisation-complete level reported in the status |
| status | output | 32 | Read data, state, request flag, sync-idle, init-done |
| cmd_err | output | 1 | Sticky flag for a command dropped while busy |
| slv_req | output | 1 | Request toward the slave |
| slv_we | output | 1 | Request direction, 1 = write |
| slv_addr | output | 16 | Even byte address toward the slave |
| slv_wdata | output | 16 | Write data toward the slave |
| slv_ack | input | 1 | Slave acknowledge of the request |
| slv_rvalid | input | 1 | Slave read data valid beat |
| slv_rdata | input | 16 | Slave read data |

## Verification
The hardest state to reach from the ports is WAIT_DATA. A well-behaved slave returns data soon after its acknowledge, so the sequencer spends almost no time there. The bench slave model therefore has a hold switch that withholds the data beat, which lets the stimulus observe state 4 with sync-idle low. The second hard case is a command that collides with a parked read. The bench parks a read in WAIT_CLEAR and then issues a write. It checks that no slave request appears, and afterwards it reads the target register back to show the write never landed.

// File: rtl/regacc_pkg.sv
package regacc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_REQ    = 3'd2,
      ST_WDATA  = 3'd4,
      ST_WCLEAR = 3'd6
   } acc_state_e;

   localparam int STATE_W = 3;
   localparam int FLAG_W  = 3;

endpackage

// File: rtl/regacc_cmd_unpack.sv
module regacc_cmd_unpack #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   localparam int CMD_W = ADDR_W + DATA_W
) (
   input  logic [CMD_W-1:0]  word,
   output logic              is_write,
   output logic [ADDR_W-1:0] byte_addr,
   output logic [DATA_W-1:0] wdata
);
   localparam int HALF_W  = ADDR_W - 1;
   localparam int HALF_LO = DATA_W;
   localparam int HALF_HI = DATA_W + HALF_W - 1;

   logic [HALF_W-1:0] half_addr;

   assign is_write  = word[CMD_W-1];
   assign half_addr = word[HALF_HI:HALF_LO];
   assign byte_addr = {half_addr, 1'b0};
   assign wdata     = word[DATA_W-1:0];

endmodule

// File: rtl/regacc_fsm.sv
module regacc_fsm
   import regacc_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 16,
   parameter bit KEEP_RDATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic              cmd_is_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              vclr_fire,
   input  logic              slv_ack,
   input  logic              slv_rvalid,
   input  logic [DATA_W-1:0] slv_rdata,
   output acc_state_e        state,
   output logic              reject,
   output logic              slv_req,
   output logic              slv_we,
   output logic [ADDR_W-1:0] slv_addr,
   output logic [DATA_W-1:0] slv_wdata,
   output logic [DATA_W-1:0] rdata
);
   acc_state_e        state_q, state_d;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              accept;
   logic              capture;
   logic              release_rd;

   assign accept     = cmd_wr && (state_q == ST_IDLE);
   assign reject     = cmd_wr && (state_q != ST_IDLE);
   assign capture    = (state_q == ST_WDATA) && slv_rvalid;
   assign release_rd = (state_q == ST_WCLEAR) && vclr_fire;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (accept)     state_d = ST_REQ;
         ST_REQ:    if (slv_ack)    state_d = we_q ? ST_IDLE : ST_WDATA;
         ST_WDATA:  if (slv_rvalid) state_d = ST_WCLEAR;
         ST_WCLEAR: if (vclr_fire)  state_d = ST_IDLE;
         default:                   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            we_q    <= cmd_is_write;
            addr_q  <= cmd_addr;
            wdata_q <= cmd_wdata;
         end
      end
   end

   generate
      if (KEEP_RDATA) begin : g_keep_rdata
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       rdata_q <= '0;
            else if (capture) rdata_q <= slv_rdata;
         end
         logic unused_rel;
         assign unused_rel = release_rd;
      end else begin : g_clear_rdata
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          rdata_q <= '0;
            else if (capture)    rdata_q <= slv_rdata;
            else if (release_rd) rdata_q <= '0;
         end
      end
   endgenerate

   assign state     = state_q;
   assign slv_req   = (state_q == ST_REQ);
   assign slv_we    = we_q;
   assign slv_addr  = addr_q;
   assign slv_wdata = wdata_q;
   assign rdata     = rdata_q;

endmodule

// File: rtl/regacc_status.sv
module regacc_status
   import regacc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int STAT_W = 32
) (
   input  acc_state_e        state,
   input  logic [DATA_W-1:0] rdata,
   input  logic              init_done,
   output logic [STAT_W-1:0] status
);
   localparam int USED_W = DATA_W + STATE_W + FLAG_W;
   localparam int ST_LO  = DATA_W;
   localparam int REQ_B  = DATA_W + STATE_W;
   localparam int SYNC_B = REQ_B + 1;
   localparam int INIT_B = REQ_B + 2;

   logic req_flag;
   logic sync_idle;

   assign req_flag  = (state == ST_REQ);
   assign sync_idle = !((state == ST_REQ) || (state == ST_WDATA));

   assign status[DATA_W-1:0]          = rdata;
   assign status[ST_LO+STATE_W-1:ST_LO] = state;
   assign status[REQ_B]               = req_flag;
   assign status[SYNC_B]              = sync_idle;
   assign status[INIT_B]              = init_done;

   generate
      if (STAT_W > USED_W) begin : g_pad
         assign status[STAT_W-1:USED_W] = '0;
      end
   endgenerate

endmodule

// File: rtl/regacc_err.sv
module regacc_err (
   input  logic clk,
   input  logic rst_n,
   input  logic reject,
   output logic err
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      err <= 1'b0;
      else if (reject) err <= 1'b1;
   end
endmodule

// File: rtl/regacc_channel.sv
module regacc_channel
   import regacc_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 16,
   parameter bit KEEP_RDATA = 1'b1,
   localparam int CMD_W     = ADDR_W + DATA_W,
   localparam int USED_W    = DATA_W + STATE_W + FLAG_W,
   localparam int STAT_W    = ((USED_W + 31) / 32) * 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [CMD_W-1:0]  cmd_data,
   input  logic              vclr_wr,
   input  logic              vclr_val,
   input  logic              init_done,
   output logic [STAT_W-1:0] status,
   output logic              cmd_err,
   output logic              slv_req,
   output logic              slv_we,
   output logic [ADDR_W-1:0] slv_addr,
   output logic [DATA_W-1:0] slv_wdata,
   input  logic              slv_ack,
   input  logic              slv_rvalid,
   input  logic [DATA_W-1:0] slv_rdata
);
   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("regacc_channel: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("regacc_channel: DATA_W must be at least 1");
      end
   endgenerate

   logic              c_write;
   logic [ADDR_W-1:0] c_addr;
   logic [DATA_W-1:0] c_wdata;
   acc_state_e        st;
   logic              rej;
   logic [DATA_W-1:0] rd;
   logic              vclr_fire;

   assign vclr_fire = vclr_wr && vclr_val;

   regacc_cmd_unpack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_unpack (
      .word      (cmd_data),
      .is_write  (c_write),
      .byte_addr (c_addr),
      .wdata     (c_wdata)
   );

   regacc_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEEP_RDATA(KEEP_RDATA)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_wr       (cmd_wr),
      .cmd_is_write (c_write),
      .cmd_addr     (c_addr),
      .cmd_wdata    (c_wdata),
      .vclr_fire    (vclr_fire),
      .slv_ack      (slv_ack),
      .slv_rvalid   (slv_rvalid),
      .slv_rdata    (slv_rdata),
      .state        (st),
      .reject       (rej),
      .slv_req      (slv_req),
      .slv_we       (slv_we),
      .slv_addr     (slv_addr),
      .slv_wdata    (slv_wdata),
      .rdata        (rd)
   );

   regacc_status #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_status (
      .state     (st),
      .rdata     (rd),
      .init_done (init_done),
      .status    (status)
   );

   regacc_err u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .reject (rej),
      .err    (cmd_err)
   );

endmodule

// File: rtl/regacc_channel_chk.sv
module regacc_channel_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int STAT_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_wr,
   input logic              vclr_wr,
   input logic              vclr_val,
   input logic [STAT_W-1:0] status,
   input logic              cmd_err,
   input logic              slv_req,
   input logic              slv_we,
   input logic [ADDR_W-1:0] slv_addr,
   input logic              slv_ack
);
   localparam int ST_LO  = DATA_W;
   localparam int SYNC_B = DATA_W + 4;

   logic [2:0]        st;
   logic [DATA_W-1:0] rd;
   assign st = status[ST_LO+2:ST_LO];
   assign rd = status[DATA_W-1:0];

   // R2: slave address is always even while requesting
   assert_even_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      slv_req |-> (slv_addr[0] == 1'b0));

   // R3: only even state codes
   assert_state_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      st[0] == 1'b0);

   // R4: request persists until acknowledged
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_req && !slv_ack) |=> slv_req);

   // R5: acknowledged write returns to idle
   assert_write_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (slv_req && slv_ack && slv_we) |=> (st == 3'd0));

   // R6: parked read keeps state and data without a release
   assert_park_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == 3'd6) && !(vclr_wr && vclr_val)) |=> ((st == 3'd6) && $stable(rd)));

   // R7: release from the parked state
   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == 3'd6) && vclr_wr && vclr_val) |=> (st == 3'd0));

   // R8: busy command flags the error, and the flag is sticky
   assert_busy_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && (st != 3'd0)) |=> cmd_err);
   assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_err |=> cmd_err);

   // R9: sync-idle low while a request is outstanding
   assert_sync_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      slv_req |-> !status[SYNC_B]);

endmodule

bind regacc_channel regacc_channel_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_wr   (cmd_wr),
   .vclr_wr  (vclr_wr),
   .vclr_val (vclr_val),
   .status   (status),
   .cmd_err  (cmd_err),
   .slv_req  (slv_req),
   .slv_we   (slv_we),
   .slv_addr (slv_addr),
   .slv_ack  (slv_ack)
);

// File: tb/regacc_channel_test.sv
`timescale 1ns/1ps
module regacc_channel_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_data = '0;
   logic        vclr_wr = 1'b0;
   logic        vclr_val = 1'b0;
   logic        init_done = 1'b0;
   logic [31:0] status;
   logic        cmd_err;
   logic        slv_req, slv_we;
   logic [15:0] slv_addr, slv_wdata;
   logic        slv_ack = 1'b0;
   logic        slv_rvalid = 1'b0;
   logic [15:0] slv_rdata = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // slave model controls
   int   ack_dly   = 0;
   bit   hold_data = 1'b0;
   int   cnt       = 0;
   bit   pend_rd   = 1'b0;
   logic [15:0] pend_addr = '0;
   logic [15:0] mem [0:15];

   always #10 clk = ~clk;

   regacc_channel uut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
      .vclr_wr(vclr_wr), .vclr_val(vclr_val), .init_done(init_done),
      .status(status), .cmd_err(cmd_err), .slv_req(slv_req), .slv_we(slv_we),
      .slv_addr(slv_addr), .slv_wdata(slv_wdata), .slv_ack(slv_ack),
      .slv_rvalid(slv_rvalid), .slv_rdata(slv_rdata)
   );

   initial begin
      for (int i = 0; i < 16; i++) mem[i] = 16'h5A00 + 16'(i);
   end

   always @(posedge clk) begin
      slv_ack    <= 1'b0;
      slv_rvalid <= 1'b0;
      if (slv_req && !slv_ack) begin
         if (cnt >= ack_dly) begin
            slv_ack <= 1'b1;
            cnt     <= 0;
            if (slv_we) mem[slv_addr[4:1]] <= slv_wdata;
            else begin
               pend_rd   <= 1'b1;
               pend_addr <= slv_addr;
            end
         end else cnt <= cnt + 1;
      end
      if (pend_rd && !hold_data) begin
         slv_rvalid <= 1'b1;
         slv_rdata  <= mem[pend_addr[4:1]];
         pend_rd    <= 1'b0;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [2:0] st();
      return status[18:16];
   endfunction

   task automatic issue(input bit wr, input logic [15:0] addr, input logic [15:0] data);
      @(negedge clk);
      cmd_data = {wr, addr[15:1], data};
      cmd_wr   = 1'b1;
      @(negedge clk);
      cmd_wr   = 1'b0;
   endtask

   task automatic wait_state(input logic [2:0] exp, input string tag);
      int n = 0;
      while (st() != exp && n < 50) begin
         @(negedge clk);
         n++;
      end
      check(tag, 32'(st()), 32'(exp));
   endtask

   task automatic release_rd(input bit val);
      @(negedge clk);
      vclr_wr  = 1'b1;
      vclr_val = val;
      @(negedge clk);
      vclr_wr  = 1'b0;
      vclr_val = 1'b0;
   endtask

   task automatic t_reset();
      check("R1 status after reset", status, 32'h0010_0000);
      check("R1 err after reset", 32'(cmd_err), 32'd0);
      check("R1 slv_req after reset", 32'(slv_req), 32'd0);
   endtask

   task automatic t_write(input logic [15:0] addr, input logic [15:0] data);
      ack_dly = 3;
      issue(1'b1, addr, data);
      check("R3 state REQ code", 32'(st()), 32'd2);
      check("R4 request flag", 32'(status[19]), 32'd1);
      check("R9 sync-idle low in REQ", 32'(status[20]), 32'd0);
      check("R2 slave we", 32'(slv_we), 32'd1);
      check("R2 slave address", 32'(slv_addr), 32'(addr));
      check("R2 slave wdata", 32'(slv_wdata), 32'(data));
      @(negedge clk);
      @(negedge clk);
      check("R4 request still held", 32'({slv_req, status[19]}), 32'd3);
      wait_state(3'd0, "R5 write back to idle without clear");
      check("R4 request flag low after ack", 32'(status[19]), 32'd0);
      ack_dly = 0;
   endtask

   task automatic t_read(input logic [15:0] addr, input logic [15:0] exp);
      issue(1'b0, addr, 16'hFFFF);
      check("R2 read direction", 32'(slv_we), 32'd0);
      wait_state(3'd6, "R6 read parks in WAIT_CLEAR");
      check("R6 read data", 32'(status[15:0]), 32'(exp));
      check("R9 sync-idle high when parked", 32'(status[20]), 32'd1);
      repeat (3) @(negedge clk);
      check("R6 still parked", 32'(st()), 32'd6);
      release_rd(1'b0);
      check("R7 clear with value 0 ignored", 32'(st()), 32'd6);
      release_rd(1'b1);
      check("R7 clear returns to idle", 32'(st()), 32'd0);
      check("R11 data kept after release", 32'(status[15:0]), 32'(exp));
   endtask

   task automatic t_wait_data();
      hold_data = 1'b1;
      issue(1'b0, 16'h0008, 16'h0);
      wait_state(3'd4, "R6 WAIT_DATA after read ack");
      check("R9 sync-idle low in WAIT_DATA", 32'(status[20]), 32'd0);
      check("R4 request flag low in WAIT_DATA", 32'(status[19]), 32'd0);
      repeat (3) @(negedge clk);
      check("R6 waits for data beat", 32'(st()), 32'd4);
      hold_data = 1'b0;
      wait_state(3'd6, "R6 WAIT_CLEAR after data beat");
      check("R6 captured data", 32'(status[15:0]), 32'h5A04);
      release_rd(1'b1);
   endtask

   task automatic t_busy();
      issue(1'b0, 16'h000A, 16'h0);
      wait_state(3'd6, "R8 setup parked read");
      check("R8 err still low before collision", 32'(cmd_err), 32'd0);
      issue(1'b1, 16'h000A, 16'hDEAD);
      check("R8 err set by busy command", 32'(cmd_err), 32'd1);
      check("R8 state unchanged", 32'(st()), 32'd6);
      check("R8 no slave request", 32'(slv_req), 32'd0);
      release_rd(1'b1);
      t_read(16'h000A, 16'h5A05);
      check("R8 err sticky", 32'(cmd_err), 32'd1);
   endtask

   task automatic t_init();
      @(negedge clk);
      init_done = 1'b1;
      #1;
      check("R10 init-done bit high", 32'(status[21]), 32'd1);
      init_done = 1'b0;
      #1;
      check("R10 init-done bit low", 32'(status[21]), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write(16'h0006, 16'hA55A);
      t_read(16'h0006, 16'hA55A);
      t_write(16'h001E, 16'h1234);
      t_read(16'h001E, 16'h1234);
      t_read(16'h0000, 16'h5A00);
      t_wait_data();
      t_init();
      t_busy();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

endmodule